// File: doc/BRIEF.md
# Multi-Mode Timer/Counter

A memory-mapped timer built around one wrap-around counter, `CNT_W` bits wide (24 by default). The counter serves four modes selected in the control register: an interval timer that stops at (or restarts after) compare A, a pulse generator whose output flip-flop toggles at compare A and at compare B, a watchdog that restarts from zero at compare A, and an off mode in which nothing counts. Each mode has its own rule for when the counter may advance and sets its own status bit.

The count clock is either the system clock, optionally slowed by a power-of-two prescaler, or a one-cycle enable pulse on `ext_tick` that is synchronous to the system clock. Software sees a bank of 32-bit words with byte-lane writes and a registered read port. A level interrupt rises when an enabled event occurs and stays high until software writes the low byte of the status word.

Top module: `multimode_timer`

## Requirements
- R1: During and after a synchronous reset, every register reads zero except compare A and compare B, which read all ones over `CNT_W` bits; `irq` and the counter are 0.
- R2: Read data appears on `bus_rdata` one cycle after `bus_rd`; unmapped word addresses read zero; control bits 4 and 3 always read 0. Word map: 0x00 control, 0x04 status, 0x08 compare A, 0x0C compare B, 0x10 interval setup, 0x20 divider, 0x30 pulse setup, 0x40 watchdog setup, 0xF0 counter.
- R3: Control bit 7 = run, bits 1:0 = mode (0 interval, 1 pulse, 2 watchdog, 3 off). In interval mode the counter advances only while run is 1 and it differs from compare A; on arriving at compare A with zero-clear (interval bit 0) clear it holds there and sets status bit 0, without further interrupts.
- R4: In interval mode with zero-clear set, the step that would reach compare A instead returns the counter to 0 and sets status bit 0.
- R5: In pulse mode (counting while run is 1), the step onto compare A toggles `ff_out` and sets status bit 1; the step onto compare B toggles `ff_out`, sets status bit 2 and returns the counter to 0.
- R6: In watchdog mode the counter advances unless run is 0 and the disable bit (watchdog bit 7) is 1; the step onto compare A sets status bit 3 and returns the counter to 0.
- R7: In mode 3 the counter never advances, whatever the run bit.
- R8: With control bit 2 clear, the counter steps every system clock when control bit 6 is 0, and once every 2^(1+D) clocks when bit 6 is 1, D being divider bits 2:0.
- R9: With control bit 2 set, the counter steps only on cycles where `ext_tick` is 1.
- R10: A write with byte strobe 0 to the status word clears all status bits and drops `irq`.
- R11: A control write with bit 7 = 0 and bit 5 = 1 clears the counter; with bit 5 = 0 the counter keeps its value.
- R12: Compare writes update only byte lanes 0 to 2 (lane 3 is ignored), and the counter wraps from all ones to 0.
- R13: A reset cycle loads `ff_out` from pulse-setup bit 0 as it stood before that cycle.
- R14: `irq` rises only for events whose enable is set (interval bit 15, pulse bit 14 for A, pulse bit 15 for B, watchdog bit 15) and stays high until cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane write strobes, bit 0 = bits 7:0 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| ext_tick | input | 1 | External count enable pulse |
| irq | output | 1 | Level interrupt |
| ff_out | output | 1 | Pulse flip-flop output |

## Verification
The bench builds the block with `CNT_W` = 12 and `ADDR_W` = 8. The narrow counter puts the wrap from 0xFFF to 0 within a few thousand cycles and makes the all-ones compare reset value and the lane-merging of compare writes easy to predict. Small compare values keep interval, pulse and watchdog periods short enough to measure high and low times of `ff_out` cycle by cycle, and a divider setting of 2 gives a thirty-odd cycle interrupt delay that stands clearly apart from the undivided one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DIV_W   = 3;
    localparam int PRE_W   = (1 << DIV_W) + 1;
    localparam int NUM_EVT = 4;

    localparam int EVT_IV = 0;
    localparam int EVT_PA = 1;
    localparam int EVT_PB = 2;
    localparam int EVT_WD = 3;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_CMPA = 8'h08;
    localparam logic [7:0] OFS_CMPB = 8'h0C;
    localparam logic [7:0] OFS_IVAL = 8'h10;
    localparam logic [7:0] OFS_DIV  = 8'h20;
    localparam logic [7:0] OFS_PULS = 8'h30;
    localparam logic [7:0] OFS_WDOG = 8'h40;
    localparam logic [7:0] OFS_CNT  = 8'hF0;

    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'd0,
        MODE_PULSE    = 2'd1,
        MODE_WDOG     = 2'd2,
        MODE_OFF      = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic      run;
        logic      div_en;
        logic      clr_en;
        logic      ext_sel;
        tmr_mode_e mode;
    } tmr_ctrl_t;

    typedef struct packed {
        tmr_ctrl_t              ctrl;
        logic [DIV_W-1:0]       div_sel;
        logic                   iv_ie;
        logic                   iv_zc;
        logic                   pb_ie;
        logic                   pa_ie;
        logic                   ffi;
        logic                   wd_ie;
        logic                   wd_dis;
    } tmr_cfg_t;

    function automatic tmr_ctrl_t ctrl_from_byte(input logic [7:0] b);
        tmr_ctrl_t c;
        c.run     = b[7];
        c.div_en  = b[6];
        c.clr_en  = b[5];
        c.ext_sel = b[2];
        c.mode    = tmr_mode_e'(b[1:0]);
        return c;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input tmr_ctrl_t c);
        return {c.run, c.div_en, c.clr_en, 2'b00, c.ext_sel, c.mode};
    endfunction

    // Last prescaler count before a tick: 2^(1+sel) - 1
    function automatic logic [PRE_W-1:0] pre_limit(input logic [DIV_W-1:0] sel);
        logic [DIV_W:0] sh;
        sh = {1'b0, sel} + 1'b1;
        return (PRE_W'(1) << sh) - PRE_W'(1);
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             div_en_i,
    input  logic             ext_sel_i,
    input  logic [DIV_W-1:0] div_sel_i,
    input  logic             ext_tick_i,
    output logic             tick_o
);

    localparam int SET_W = DIV_W + 2;

    logic [PRE_W-1:0] pre_q;
    logic [SET_W-1:0] set_q;
    logic [SET_W-1:0] settings;
    logic             changed;
    logic             at_limit;

    assign settings = {div_en_i, ext_sel_i, div_sel_i};
    assign changed  = (settings != set_q);
    assign at_limit = (pre_q == pre_limit(div_sel_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            set_q <= '0;
        end else begin
            set_q <= settings;
            if (changed || at_limit)
                pre_q <= '0;
            else
                pre_q <= pre_q + 1'b1;
        end
    end

    always_comb begin
        if (ext_sel_i)
            tick_o = ext_tick_i;
        else if (div_en_i)
            tick_o = at_limit && !changed;
        else
            tick_o = 1'b1;
    end

    // A divided tick is never followed by another within one clock
    AST_DIV_SPACING: assert property (@(posedge clk) disable iff (rst)
        (div_en_i && !ext_sel_i && tick_o) |=> !tick_o);  // R8

endmodule

// File: rtl/tmr_engine.sv
module tmr_engine
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_i,
    input  logic               run_i,
    input  tmr_mode_e          mode_i,
    input  logic               iv_zc_i,
    input  logic               wd_dis_i,
    input  logic               ffi_i,
    input  logic [CNT_W-1:0]   cmp_a_i,
    input  logic [CNT_W-1:0]   cmp_b_i,
    input  logic               cnt_clr_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [NUM_EVT-1:0] evt_o,
    output logic               ff_o
);

    logic [CNT_W-1:0] cnt_q, cnt_n, nxt;
    logic             ff_q, ff_n;
    logic             adv;

    always_comb begin
        nxt = cnt_q + 1'b1;
        unique case (mode_i)
            MODE_INTERVAL: adv = tick_i && run_i && (cnt_q != cmp_a_i);
            MODE_PULSE:    adv = tick_i && run_i;
            MODE_WDOG:     adv = tick_i && (run_i || !wd_dis_i);
            default:       adv = 1'b0;
        endcase

        cnt_n = cnt_q;
        ff_n  = ff_q;
        evt_o = '0;
        if (adv) begin
            cnt_n = nxt;
            unique case (mode_i)
                MODE_INTERVAL: begin
                    if (nxt == cmp_a_i) begin
                        evt_o[EVT_IV] = 1'b1;
                        if (iv_zc_i) cnt_n = '0;
                    end
                end
                MODE_PULSE: begin
                    if (nxt == cmp_a_i) begin
                        evt_o[EVT_PA] = 1'b1;
                        ff_n = ~ff_q;
                    end else if (nxt == cmp_b_i) begin
                        evt_o[EVT_PB] = 1'b1;
                        ff_n  = ~ff_q;
                        cnt_n = '0;
                    end
                end
                MODE_WDOG: begin
                    if (nxt == cmp_a_i) begin
                        evt_o[EVT_WD] = 1'b1;
                        cnt_n = '0;
                    end
                end
                default: ;
            endcase
        end
        if (cnt_clr_i) cnt_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ff_q  <= ffi_i;
        end else begin
            cnt_q <= cnt_n;
            ff_q  <= ff_n;
        end
    end

    assign cnt_o = cnt_q;
    assign ff_o  = ff_q;

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_OFF && !cnt_clr_i) |=> $stable(cnt_q));  // R7

    AST_IV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_INTERVAL && cnt_q == cmp_a_i && !cnt_clr_i) |=> $stable(cnt_q));  // R3

    AST_WD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_WDOG && !run_i && wd_dis_i && !cnt_clr_i) |=> $stable(cnt_q));  // R6

    AST_CTRL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cnt_clr_i |=> (cnt_q == '0));  // R11

    AST_FF_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(ff_q));  // R5

endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 8
)(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic [3:0]         bus_be,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [31:0]        bus_rdata,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic [NUM_EVT-1:0] evt_i,
    output tmr_cfg_t           cfg_o,
    output logic [CNT_W-1:0]   cmp_a_o,
    output logic [CNT_W-1:0]   cmp_b_o,
    output logic               cnt_clr_o,
    output logic               irq_o
);

    tmr_cfg_t           cfg_q;
    logic [CNT_W-1:0]   cmp_a_q, cmp_b_q;
    logic [NUM_EVT-1:0] stat_q;
    logic               irq_q;
    logic [ADDR_W-1:0]  word;
    logic               sel_ctrl, sel_stat, sel_cmpa, sel_cmpb;
    logic               sel_ival, sel_div, sel_puls, sel_wdog;
    logic               stat_clr;
    logic [NUM_EVT-1:0] ie_mask;
    logic [31:0]        rd_mux;
    logic               wdata_unused;

    assign word     = {bus_addr[ADDR_W-1:2], 2'b00};
    assign sel_ctrl = (word == ADDR_W'(OFS_CTRL));
    assign sel_stat = (word == ADDR_W'(OFS_STAT));
    assign sel_cmpa = (word == ADDR_W'(OFS_CMPA));
    assign sel_cmpb = (word == ADDR_W'(OFS_CMPB));
    assign sel_ival = (word == ADDR_W'(OFS_IVAL));
    assign sel_div  = (word == ADDR_W'(OFS_DIV));
    assign sel_puls = (word == ADDR_W'(OFS_PULS));
    assign sel_wdog = (word == ADDR_W'(OFS_WDOG));

    assign stat_clr  = bus_wr && sel_stat && bus_be[0];
    assign cnt_clr_o = bus_wr && sel_ctrl && bus_be[0] && !bus_wdata[7] && bus_wdata[5];
    assign wdata_unused = ^bus_wdata[31:24];

    always_comb begin
        ie_mask         = '0;
        ie_mask[EVT_IV] = cfg_q.iv_ie;
        ie_mask[EVT_PA] = cfg_q.pa_ie;
        ie_mask[EVT_PB] = cfg_q.pb_ie;
        ie_mask[EVT_WD] = cfg_q.wd_ie;
    end

    // Merge byte lanes 0..2 of a compare word into the held value
    function automatic logic [CNT_W-1:0] merge_cmp(input logic [CNT_W-1:0] old,
                                                   input logic [31:0] wd,
                                                   input logic [3:0] be);
        logic [31:0] m;
        m = 32'(old);
        for (int b = 0; b < 3; b++)
            if (be[b]) m[8*b +: 8] = wd[8*b +: 8];
        return m[CNT_W-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            cmp_a_q <= '1;
            cmp_b_q <= '1;
            stat_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (bus_wr) begin
                if (sel_ctrl && bus_be[0]) cfg_q.ctrl <= ctrl_from_byte(bus_wdata[7:0]);
                if (sel_cmpa) cmp_a_q <= merge_cmp(cmp_a_q, bus_wdata, bus_be);
                if (sel_cmpb) cmp_b_q <= merge_cmp(cmp_b_q, bus_wdata, bus_be);
                if (sel_ival && bus_be[1]) cfg_q.iv_ie  <= bus_wdata[15];
                if (sel_ival && bus_be[0]) cfg_q.iv_zc  <= bus_wdata[0];
                if (sel_div  && bus_be[0]) cfg_q.div_sel <= bus_wdata[DIV_W-1:0];
                if (sel_puls && bus_be[1]) begin
                    cfg_q.pb_ie <= bus_wdata[15];
                    cfg_q.pa_ie <= bus_wdata[14];
                end
                if (sel_puls && bus_be[0]) cfg_q.ffi    <= bus_wdata[0];
                if (sel_wdog && bus_be[1]) cfg_q.wd_ie  <= bus_wdata[15];
                if (sel_wdog && bus_be[0]) cfg_q.wd_dis <= bus_wdata[7];
            end
            stat_q <= (stat_clr ? '0 : stat_q) | evt_i;
            irq_q  <= (stat_clr ? 1'b0 : irq_q) | (|(evt_i & ie_mask));
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (1'b1)
            sel_ctrl: rd_mux = {24'h0, ctrl_to_byte(cfg_q.ctrl)};
            sel_stat: rd_mux = 32'(stat_q);
            sel_cmpa: rd_mux = 32'(cmp_a_q);
            sel_cmpb: rd_mux = 32'(cmp_b_q);
            sel_ival: rd_mux = {16'h0, cfg_q.iv_ie, 14'h0, cfg_q.iv_zc};
            sel_div:  rd_mux = 32'(cfg_q.div_sel);
            sel_puls: rd_mux = {16'h0, cfg_q.pb_ie, cfg_q.pa_ie, 13'h0, cfg_q.ffi};
            sel_wdog: rd_mux = {16'h0, cfg_q.wd_ie, 7'h0, cfg_q.wd_dis, 7'h0};
            default:  rd_mux = (word == ADDR_W'(OFS_CNT)) ? 32'(cnt_i) : 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= bus_rd ? rd_mux : 32'h0;
    end

    assign cfg_o   = cfg_q;
    assign cmp_a_o = cmp_a_q;
    assign cmp_b_o = cmp_b_q;
    assign irq_o   = irq_q;

    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && evt_i == '0) |=> (stat_q == '0 && !irq_q));  // R10

    AST_IRQ_HAS_STATUS: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (stat_q != '0));  // R14

    AST_EVT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt_i));  // R5

endmodule

// File: rtl/multimode_timer.sv
module multimode_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic              ext_tick,
    output logic              irq,
    output logic              ff_out
);

    tmr_cfg_t           cfg;
    logic [CNT_W-1:0]   cmp_a, cmp_b, cnt;
    logic [NUM_EVT-1:0] evt;
    logic               cnt_clr;
    logic               tick;
    logic               cfg_unused;

    assign cfg_unused = cfg.ctrl.clr_en ^ cfg.iv_ie ^ cfg.pa_ie ^ cfg.pb_ie ^ cfg.wd_ie;

    tmr_regfile #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cnt_i(cnt), .evt_i(evt),
        .cfg_o(cfg), .cmp_a_o(cmp_a), .cmp_b_o(cmp_b),
        .cnt_clr_o(cnt_clr), .irq_o(irq)
    );

    tmr_prescale u_pre (
        .clk(clk), .rst(rst),
        .div_en_i(cfg.ctrl.div_en), .ext_sel_i(cfg.ctrl.ext_sel),
        .div_sel_i(cfg.div_sel), .ext_tick_i(ext_tick), .tick_o(tick)
    );

    tmr_engine #(.CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst(rst), .tick_i(tick),
        .run_i(cfg.ctrl.run), .mode_i(cfg.ctrl.mode),
        .iv_zc_i(cfg.iv_zc), .wd_dis_i(cfg.wd_dis), .ffi_i(cfg.ffi),
        .cmp_a_i(cmp_a), .cmp_b_i(cmp_b), .cnt_clr_i(cnt_clr),
        .cnt_o(cnt), .evt_o(evt), .ff_o(ff_out)
    );

endmodule

// File: tb/sim_multimode_timer.sv
module sim_multimode_timer;

    localparam int CW = 12;
    localparam logic [31:0] ONES = (32'h1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        ext_tick = 1'b0;
    logic        irq, ff_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    multimode_timer #(.CNT_W(CW), .ADDR_W(8)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ext_tick(ext_tick), .irq(irq), .ff_out(ff_out)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input longint act, input longint lo, input longint hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic do_reset(input int n);
        @(negedge clk); rst = 1'b1;
        repeat (n) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset(3);
        check("R1 irq", irq, 0);
        check("R1 ff", ff_out, 0);
        rd(8'h00, d); check("R1 ctrl", d, 0);
        rd(8'h04, d); check("R1 status", d, 0);
        rd(8'h08, d); check("R1 cmpA", d, ONES);
        rd(8'h0C, d); check("R1 cmpB", d, ONES);
        rd(8'h30, d); check("R1 pulse setup", d, 0);
        rd(8'hF0, d); check("R1 counter", d, 0);
        rd(8'h14, d); check("R2 unmapped", d, 0);
        wr(8'h00, 32'hFF, 4'h1);
        rd(8'h00, d); check("R2 ctrl bits 4,3", d, 32'hE7);
    endtask

    task automatic t_interval_hold();
        logic [31:0] d;
        do_reset(2);
        wr(8'h08, 5, 4'hF);
        wr(8'h10, 32'h8000, 4'hF);
        wr(8'h00, 32'h80, 4'h1);
        repeat (20) @(negedge clk);
        rd(8'hF0, d); check("R3 held at A", d, 5);
        rd(8'h04, d); check("R3 status bit0", d, 1);
        check("R14 irq enabled", irq, 1);
        wr(8'h04, 0, 4'h1);
        rd(8'h04, d); check("R10 status cleared", d, 0);
        check("R10 irq dropped", irq, 0);
        repeat (10) @(negedge clk);
        rd(8'hF0, d); check("R3 still at A", d, 5);
        check("R3 no re-interrupt", irq, 0);
    endtask

    task automatic t_interval_zc();
        logic [31:0] d;
        do_reset(2);
        wr(8'h08, 5, 4'hF);
        wr(8'h10, 32'h0001, 4'hF);
        wr(8'h00, 32'h80, 4'h1);
        for (int i = 0; i < 6; i++) begin
            repeat (3) @(negedge clk);
            rd(8'hF0, d); check_range("R4 below A", d, 0, 4);
        end
        rd(8'h04, d); check("R4 status bit0", d, 1);
        check("R14 irq disabled", irq, 0);
    endtask

    task automatic t_pulse();
        logic [31:0] d;
        int hi, lo, guard;
        do_reset(2);
        wr(8'h08, 3, 4'hF);
        wr(8'h0C, 7, 4'hF);
        wr(8'h30, 32'h4000, 4'hF);
        wr(8'h00, 32'h81, 4'h1);
        guard = 0;
        while (ff_out == 1'b0 && guard < 50) begin @(negedge clk); guard++; end
        hi = 0; while (ff_out == 1'b1 && hi < 50) begin @(negedge clk); hi++; end
        lo = 0; while (ff_out == 1'b0 && lo < 50) begin @(negedge clk); lo++; end
        check("R5 high time B-A", hi, 4);
        check("R5 low time A", lo, 3);
        rd(8'h04, d); check("R5 status bits 1,2", d, 6);
        check("R14 irq from A", irq, 1);
        wr(8'h30, 32'h0000, 4'hF);
        wr(8'h04, 0, 4'h1);
        repeat (20) @(negedge clk);
        rd(8'h04, d); check("R5 status again", d, 6);
        check("R14 no irq when disabled", irq, 0);
    endtask

    task automatic t_watchdog();
        logic [31:0] d, d2;
        do_reset(2);
        wr(8'h08, 10, 4'hF);
        wr(8'h40, 32'h8000, 4'hF);
        wr(8'h00, 32'h02, 4'h1);
        repeat (25) @(negedge clk);
        rd(8'h04, d); check("R6 status bit3", d, 8);
        check("R6 irq", irq, 1);
        rd(8'hF0, d); check_range("R6 cleared at A", d, 0, 9);
        wr(8'h40, 32'h8080, 4'hF);
        rd(8'hF0, d);
        repeat (10) @(negedge clk);
        rd(8'hF0, d2); check("R6 held when disabled", d2, d);
    endtask

    task automatic t_off();
        logic [31:0] d;
        do_reset(2);
        wr(8'h00, 32'h83, 4'h1);
        repeat (20) @(negedge clk);
        rd(8'hF0, d); check("R7 mode off", d, 0);
    endtask

    task automatic t_div();
        int n;
        do_reset(2);
        wr(8'h08, 4, 4'hF);
        wr(8'h10, 32'h8000, 4'hF);
        wr(8'h00, 32'h80, 4'h1);
        n = 0; while (!irq && n < 200) begin @(negedge clk); n++; end
        check_range("R8 undivided", n, 3, 6);
        do_reset(2);
        wr(8'h08, 4, 4'hF);
        wr(8'h10, 32'h8000, 4'hF);
        wr(8'h20, 2, 4'h1);
        wr(8'h00, 32'hC0, 4'h1);
        n = 0; while (!irq && n < 200) begin @(negedge clk); n++; end
        check_range("R8 divide by 8", n, 30, 36);
    endtask

    task automatic t_ext();
        logic [31:0] d;
        do_reset(2);
        wr(8'h00, 32'h84, 4'h1);
        repeat (20) @(negedge clk);
        rd(8'hF0, d); check("R9 no pulses", d, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); ext_tick = 1'b1;
            @(negedge clk); ext_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
        rd(8'hF0, d); check("R9 five pulses", d, 5);
        wr(8'h00, 32'h04, 4'h1);
        rd(8'hF0, d); check("R11 no clear without bit5", d, 5);
        wr(8'h00, 32'h20, 4'h1);
        rd(8'hF0, d); check("R11 clear", d, 0);
    endtask

    task automatic t_compare();
        logic [31:0] d;
        do_reset(2);
        wr(8'h08, 32'hFFFFFF12, 4'b0001);
        rd(8'h08, d); check("R12 lane0", d, 32'hF12);
        wr(8'h08, 32'h00000000, 4'b1000);
        rd(8'h08, d); check("R12 lane3 ignored", d, 32'hF12);
        wr(8'h08, 32'h00000300, 4'b0010);
        rd(8'h08, d); check("R12 lane1", d, 32'h312);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        do_reset(2);
        wr(8'h00, 32'h81, 4'h1);
        repeat (4150) @(negedge clk);
        rd(8'hF0, d); check_range("R12 wrapped", d, 1, 200);
        check("R12 ff toggled once", ff_out, 1);
    endtask

    task automatic t_ffi();
        logic [31:0] d;
        do_reset(2);
        wr(8'h30, 32'h0001, 4'h1);
        do_reset(1);
        check("R13 ff preset", ff_out, 1);
        rd(8'h30, d); check("R13 setup cleared", d, 0);
    endtask

    initial begin
        t_reset();
        t_interval_hold();
        t_interval_zc();
        t_pulse();
        t_watchdog();
        t_off();
        t_div();
        t_ext();
        t_compare();
        t_wrap();
        t_ffi();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule